// File: doc/BRIEF.md
# Encoder Frame Master with Line-Delay Compensation

This block is the controller side of a point-to-point serial link to an absolute position sensor. It drives a clock line and reads a single data line back. When `start` is pulsed it runs one frame. The first rising clock edge tells the sensor to freeze its position. The sensor acknowledges the second rising edge by pulling the data line low. The master counts the system-clock cycles from that edge to the first low it observes, and this count is the round-trip line delay. Every later bit is then sampled that many cycles after the rising edge that launched it. Long cables therefore cost latency but do not reduce the bit rate.

After the acknowledge, the master keeps clocking through the sensor's busy period until a high start bit arrives. It then reads one side-channel bit, the position (most significant bit first), an error bit, a warning bit and a six-bit check code. When the frame ends, it holds the clock line at the level of one control bit for a fixed hold period. This passes one side-channel bit per frame to the sensor. The sensor returns that bit in the next frame, and the master compares the two. A frame with a bad check code is reported and its data is discarded. A missing acknowledge or a missing start bit ends the frame with a timeout flag.

Top module: `encoder_frame_master`

## Requirements
- R1: After reset the clock output is high, `busy_o` and `done_o` are low, and every result output is zero. The clock output is high whenever `busy_o` is low.
- R2: On `start` the master raises `busy_o` and keeps the clock high for `half_div` cycles. It then toggles the clock every `half_div` cycles. On a good frame it pulses `done_o` for one cycle. `pos_o` changes only in that cycle.
- R3: The delay from the second rising clock edge to the first low seen on the data line is measured in system cycles. Every later bit is sampled that same number of cycles after its launching rising edge. Frames read correctly for any delay shorter than one clock period.
- R4: Any number of low busy bits up to `BUSY_LIMIT` may follow the acknowledge. The master keeps clocking, and the first high bit is taken as the start bit.
- R5: The check code is 6 bits with polynomial x^6+x+1 and a zero start value. It is computed over the position, error and warning bits and sent inverted, most significant bit first. On a mismatch `crc_fail_o` is 1 at `done_o`, and `pos_o`, `err_o` and `warn_o` keep their previous values.
- R6: The error and warning bits are active low on the line. `err_o` and `warn_o` report them active high.
- R7: After the last check-code bit the clock is held at the `cdm_i` level that was sampled at `start`, for `TOUT_CYC` cycles. It then returns high and `busy_o` falls.
- R8: `echo_err_o` is 1 at `done_o` when the received side-channel bit differs from the control bit sent in the previous completed frame. After reset, that previous bit is taken as 0.
- R9: If no low is seen before `ACK_PERIODS` further rising edges after the second rising edge, the frame ends with `timeout_o`=1 and `done_o`. In that case `crc_fail_o` and `echo_err_o` are 0, `pos_o` is unchanged, and the clock goes high.
- R10: If `BUSY_LIMIT` sampled bits after the acknowledge are all low, the frame ends with `timeout_o`=1 and `pos_o` unchanged.
- R11: `pos_len` (1 to `POS_MAX`) sets the number of position bits in a frame. The result is right-aligned in `pos_o` with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one frame (taken while idle) |
| cdm_i | input | 1 | Control bit to send after this frame |
| half_div | input | DIV_W | Clock half period in system cycles |
| pos_len | input | LEN_W | Position bits per frame |
| sl_i | input | 1 | Data line from the sensor |
| ma_o | output | 1 | Clock line to the sensor |
| busy_o | output | 1 | Frame or hold period in progress |
| done_o | output | 1 | One-cycle frame-end strobe |
| pos_o | output | POS_MAX | Last good position |
| err_o | output | 1 | Sensor error, active high |
| warn_o | output | 1 | Sensor warning, active high |
| crc_fail_o | output | 1 | Check code mismatch in last frame |
| echo_err_o | output | 1 | Returned side-channel bit mismatch |
| timeout_o | output | 1 | Last frame aborted |

## Verification
If the measured delay is wrong, every bit is sampled in the wrong slot. The position then shows up shifted, and the check code fails at the `done_o` of that same frame. A wrong bit counter or a wrong length register makes the frame end early or late, which also produces a check-code failure in that frame. A stale control-bit register is only seen in the next frame, through `echo_err_o`, or through the hold level that the sensor observes. The bench covers several dividers, line delays and busy lengths for this reason, and it runs back-to-back frames with alternating control bits.

// File: rtl/enc_pkg.sv
// Shared types and the serial check-code step for the encoder frame master.
// Assumes a 6-bit code, polynomial x^6+x+1, shifted most significant bit first.
package enc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_TRIG,
        ST_ACK,
        ST_BUSY,
        ST_CDS,
        ST_DATA,
        ST_CRC,
        ST_HOLD,
        ST_ABORT
    } mst_state_t;

    localparam int          CRC_W    = 6;
    localparam logic [5:0]  CRC_POLY = 6'h03;

    // One serial step of the check code.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/enc_line_sync.sv
// Synchronizer chain for the returning data line.
// Resets to high, which is the idle level of the line. Its latency ends up
// inside the measured line delay, so later stages need no correction for it.
module enc_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh;

    // Shift the line level through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d_i};
    end

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/enc_sclk_gen.sv
// Clock-line generator. While run_i is high it toggles every half_i cycles,
// starting from the high level. Otherwise it drives hold_lvl_i when
// hold_en_i is set, and high when it is not.
// rise_o marks the cycle whose clock edge drives the line from low to high.
// A half_i of 0 is treated as 1.
module enc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             hold_en_i,
    input  logic             hold_lvl_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             ma_o,
    output logic             rise_o
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;
    logic             tick;

    assign half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
    assign tick     = run_i && (cnt == half_eff - DIV_W'(1));
    assign rise_o   = tick && !ma_o;

    // Half-period counter and line level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            ma_o <= 1'b1;
        end else if (run_i) begin
            if (tick) begin
                cnt  <= '0;
                ma_o <= ~ma_o;
            end else begin
                cnt  <= cnt + DIV_W'(1);
            end
        end else begin
            cnt  <= '0;
            ma_o <= hold_en_i ? hold_lvl_i : 1'b1;
        end
    end
endmodule

// File: rtl/enc_crc6.sv
// Serial check-code accumulator. It is cleared with clr_i and advanced by
// one bit for each cycle in which en_i is high.
module enc_crc6 import enc_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    // Accumulate the code over the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc_o <= '0;
        else if (clr_i) crc_o <= '0;
        else if (en_i)  crc_o <= crc_step(crc_o, bit_i);
    end
endmodule

// File: rtl/encoder_frame_master.sv
// Encoder frame master. Runs one position frame for each start request:
// clock bursts, line-delay measurement at the acknowledge, delay-compensated
// sampling, check-code test, control-bit hold and echo comparison.
// Assumes the round-trip delay plus the synchronizer latency stays below one
// clock period (2*half_div cycles), that pos_len is within 1..POS_MAX, and
// that the data line idles high.
module encoder_frame_master import enc_pkg::*; #(
    parameter int POS_MAX     = 32,
    parameter int DIV_W       = 8,
    parameter int DLY_W       = 8,
    parameter int ACK_PERIODS = 1,
    parameter int BUSY_LIMIT  = 64,
    parameter int TOUT_CYC    = 40,
    parameter int SYNC_STAGES = 2,
    localparam int LEN_W      = $clog2(POS_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               cdm_i,
    input  logic [DIV_W-1:0]   half_div,
    input  logic [LEN_W-1:0]   pos_len,
    input  logic               sl_i,
    output logic               ma_o,
    output logic               busy_o,
    output logic               done_o,
    output logic [POS_MAX-1:0] pos_o,
    output logic               err_o,
    output logic               warn_o,
    output logic               crc_fail_o,
    output logic               echo_err_o,
    output logic               timeout_o
);
    localparam int IDX_W  = LEN_W + 1;
    localparam int WMAX   = (BUSY_LIMIT > ACK_PERIODS) ? BUSY_LIMIT : ACK_PERIODS;
    localparam int WAIT_W = $clog2(WMAX + 1);
    localparam int TOUT_W = $clog2(TOUT_CYC + 1);

    mst_state_t         state;
    logic               sl_s, run, hold_en, rise, sample, second_rise;
    logic [DLY_W-1:0]   since_rise, dly_q;
    logic [WAIT_W-1:0]  wait_cnt;
    logic [TOUT_W-1:0]  tout_cnt;
    logic [IDX_W-1:0]   idx, len_ext;
    logic [LEN_W-1:0]   len_q;
    logic [POS_MAX-1:0] pos_sh;
    logic [CRC_W-2:0]   rx_crc;
    logic [CRC_W-1:0]   crc_v;
    logic               cds_q, err_n, warn_n, cdm_q, prev_cdm, crc_ok;

    enc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sl_i), .q_o(sl_s)
    );

    assign run     = state inside {ST_TRIG, ST_ACK, ST_BUSY, ST_CDS, ST_DATA, ST_CRC};
    assign hold_en = (state == ST_HOLD) && (tout_cnt != TOUT_W'(TOUT_CYC - 1));

    enc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk(clk), .rst_n(rst_n), .run_i(run), .hold_en_i(hold_en),
        .hold_lvl_i(cdm_q), .half_i(half_div), .ma_o(ma_o), .rise_o(rise)
    );

    enc_crc6 u_crc (
        .clk(clk), .rst_n(rst_n), .clr_i(state == ST_CDS),
        .en_i((state == ST_DATA) && sample), .bit_i(sl_s), .crc_o(crc_v)
    );

    assign sample  = (since_rise == dly_q);
    assign len_ext = {1'b0, len_q};
    assign crc_ok  = ({rx_crc, sl_s} == ~crc_v);
    assign busy_o  = (state != ST_IDLE);

    // Cycles elapsed since the last rising clock edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                   since_rise <= '0;
        else if (rise)                since_rise <= '0;
        else if (since_rise != '1)    since_rise <= since_rise + DLY_W'(1);
    end

    // Frame sequencer: measures the delay, collects bits and updates the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  second_rise <= 1'b0; wait_cnt <= '0; tout_cnt <= '0;
            dly_q <= '0;       idx <= '0;           len_q <= '0;    pos_sh <= '0;
            rx_crc <= '0;      cds_q <= 1'b0;       err_n <= 1'b1;  warn_n <= 1'b1;
            cdm_q <= 1'b0;     prev_cdm <= 1'b0;    done_o <= 1'b0; pos_o <= '0;
            err_o <= 1'b0;     warn_o <= 1'b0;      crc_fail_o <= 1'b0;
            echo_err_o <= 1'b0; timeout_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    state       <= ST_TRIG;
                    cdm_q       <= cdm_i;
                    len_q       <= pos_len;
                    second_rise <= 1'b0;
                end
                ST_TRIG: if (rise) begin
                    if (second_rise) begin
                        state    <= ST_ACK;
                        wait_cnt <= '0;
                    end
                    second_rise <= 1'b1;
                end
                ST_ACK: begin
                    if (!sl_s) begin
                        dly_q    <= since_rise;
                        state    <= ST_BUSY;
                        wait_cnt <= '0;
                    end else if (rise) begin
                        if (wait_cnt == WAIT_W'(ACK_PERIODS - 1)) begin
                            state <= ST_ABORT;  tout_cnt <= '0;   done_o <= 1'b1;
                            timeout_o <= 1'b1;  crc_fail_o <= 1'b0; echo_err_o <= 1'b0;
                        end else begin
                            wait_cnt <= wait_cnt + WAIT_W'(1);
                        end
                    end
                end
                ST_BUSY: if (sample) begin
                    if (sl_s) begin
                        state <= ST_CDS;
                    end else if (wait_cnt == WAIT_W'(BUSY_LIMIT - 1)) begin
                        state <= ST_ABORT;  tout_cnt <= '0;   done_o <= 1'b1;
                        timeout_o <= 1'b1;  crc_fail_o <= 1'b0; echo_err_o <= 1'b0;
                    end else begin
                        wait_cnt <= wait_cnt + WAIT_W'(1);
                    end
                end
                ST_CDS: if (sample) begin
                    cds_q  <= sl_s;
                    idx    <= '0;
                    pos_sh <= '0;
                    state  <= ST_DATA;
                end
                ST_DATA: if (sample) begin
                    idx <= idx + IDX_W'(1);
                    if (idx < len_ext) begin
                        pos_sh <= {pos_sh[POS_MAX-2:0], sl_s};
                    end else if (idx == len_ext) begin
                        err_n <= sl_s;
                    end else begin
                        warn_n <= sl_s;
                        idx    <= '0;
                        state  <= ST_CRC;
                    end
                end
                ST_CRC: if (sample) begin
                    rx_crc <= {rx_crc[CRC_W-3:0], sl_s};
                    idx    <= idx + IDX_W'(1);
                    if (idx == IDX_W'(CRC_W - 1)) begin
                        state      <= ST_HOLD;
                        tout_cnt   <= '0;
                        done_o     <= 1'b1;
                        timeout_o  <= 1'b0;
                        crc_fail_o <= !crc_ok;
                        echo_err_o <= (cds_q != prev_cdm);
                        prev_cdm   <= cdm_q;
                        if (crc_ok) begin
                            pos_o  <= pos_sh;
                            err_o  <= !err_n;
                            warn_o <= !warn_n;
                        end
                    end
                end
                ST_HOLD, ST_ABORT: begin
                    tout_cnt <= tout_cnt + TOUT_W'(1);
                    if (tout_cnt == TOUT_W'(TOUT_CYC - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/enc_master_chk.sv
// Property checker for the encoder frame master, bound to every instance.
module enc_master_chk #(
    parameter int POS_MAX = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ma_o,
    input logic               busy_o,
    input logic               done_o,
    input logic [POS_MAX-1:0] pos_o,
    input logic               crc_fail_o,
    input logic               echo_err_o,
    input logic               timeout_o
);
    // R1: the clock line idles high outside a frame.
    assert_idle_ma_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ma_o);

    // R2: a frame starts from a high clock line.
    assert_start_from_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ma_o);

    // R2: the end-of-frame strobe lasts one cycle.
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: the position changes only together with the strobe.
    assert_pos_only_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(pos_o));

    // R5: a failed check code leaves the position untouched.
    assert_crc_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && crc_fail_o) |-> $stable(pos_o));

    // R9: an aborted frame reports neither code nor echo errors and keeps the position.
    assert_timeout_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> (!crc_fail_o && !echo_err_o && $stable(pos_o)));
endmodule

bind encoder_frame_master enc_master_chk #(.POS_MAX(POS_MAX)) u_chk (
    .clk(clk), .rst_n(rst_n), .ma_o(ma_o), .busy_o(busy_o), .done_o(done_o),
    .pos_o(pos_o), .crc_fail_o(crc_fail_o), .echo_err_o(echo_err_o),
    .timeout_o(timeout_o)
);

// File: tb/encoder_frame_master_tb.sv
// Directed bench: a behavioural sensor with a configurable line delay answers
// the master. Each scenario task runs frames and checks the results itself.
module encoder_frame_master_tb;
    localparam int POS_MAX = 32;
    localparam int LEN_W   = $clog2(POS_MAX + 1);
    localparam int QUIET   = 24;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cdm_i = 1'b0;
    logic [7:0] half_div = 8'd4;
    logic [LEN_W-1:0] pos_len = LEN_W'(24);
    logic sl;
    logic ma_o, busy_o, done_o, err_o, warn_o, crc_fail_o, echo_err_o, timeout_o;
    logic [POS_MAX-1:0] pos_o;

    encoder_frame_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cdm_i(cdm_i), .half_div(half_div),
        .pos_len(pos_len), .sl_i(sl), .ma_o(ma_o), .busy_o(busy_o), .done_o(done_o),
        .pos_o(pos_o), .err_o(err_o), .warn_o(warn_o), .crc_fail_o(crc_fail_o),
        .echo_err_o(echo_err_o), .timeout_o(timeout_o)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // Sensor model configuration and state.
    logic [31:0] s_pos;
    int s_len, s_busy, lat;
    logic s_errn, s_warnn, s_flip, s_corrupt, s_hang, s_noack;
    logic [255:0] seq;
    int seq_len, rcnt, quiet;
    logic sout, ma_prev, frame_sent, cdm_seen;
    logic [15:0] pipe;

    assign sl = pipe[lat];

    function automatic logic [5:0] ref_crc(input logic [31:0] p, input int len,
                                           input logic e, input logic w);
        logic [5:0] c = '0;
        logic b, fb;
        for (int i = len + 1; i >= 0; i--) begin
            b  = (i == 1) ? e : (i == 0) ? w : p[i-2];
            fb = c[5] ^ b;
            c  = {c[4:0], 1'b0} ^ (fb ? 6'h03 : 6'h00);
        end
        return c;
    endfunction

    task put_bit(input logic b);
        seq[seq_len] = b;
        seq_len++;
    endtask

    task build_seq();
        logic [5:0] c;
        seq_len = 0;
        put_bit(1'b0);
        for (int i = 0; i < s_busy; i++) put_bit(1'b0);
        put_bit(1'b1);
        put_bit(cdm_seen ^ s_flip);
        for (int i = s_len - 1; i >= 0; i--) put_bit(s_pos[i]);
        put_bit(s_errn);
        put_bit(s_warnn);
        c = ref_crc(s_pos, s_len, s_errn, s_warnn);
        for (int k = 5; k >= 0; k--) put_bit(~c[k] ^ (s_corrupt && k == 0));
    endtask

    // Sensor: answers each rising clock edge, and reads the control bit once the line stays quiet.
    always @(negedge clk) begin
        if (!rst_n) begin
            rcnt = 0; sout = 1'b1; quiet = 0; ma_prev = 1'b1;
            frame_sent = 1'b0; cdm_seen = 1'b0;
        end else begin
            if (ma_o && !ma_prev) begin
                rcnt = rcnt + 1;
                if (rcnt == 1) build_seq();
                else if (s_noack) sout = 1'b1;
                else if (s_hang) sout = 1'b0;
                else if (rcnt - 2 < seq_len) begin
                    sout = seq[rcnt-2];
                    if (rcnt - 2 == seq_len - 1) frame_sent = 1'b1;
                end else sout = 1'b1;
            end
            if (ma_o == ma_prev) quiet = quiet + 1;
            else quiet = 0;
            if (quiet == QUIET) begin
                if (frame_sent) cdm_seen = ma_o;
                frame_sent = 1'b0; rcnt = 0; sout = 1'b1;
            end
            ma_prev = ma_o;
        end
        pipe <= {pipe[14:0], sout};
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected state kept by the bench.
    logic [31:0] exp_pos = '0;
    logic exp_err = 0, exp_warn = 0, exp_prev_cdm = 0;

    task automatic run_frame(input logic [31:0] p, input int len, input logic en,
                             input logic wn, input int busy, input logic cdm,
                             input int lt, input int dv, input logic flip,
                             input logic corrupt, input logic hang, input logic noack);
        int guard;
        s_pos = p & ((len == 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1));
        s_len = len; s_errn = en; s_warnn = wn; s_busy = busy;
        s_flip = flip; s_corrupt = corrupt; s_hang = hang; s_noack = noack;
        lat = lt; half_div = 8'(dv); pos_len = LEN_W'(len); cdm_i = cdm;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        guard = 0;
        while (!done_o && guard < 20000) begin @(negedge clk); guard++; end
        chk(done_o == 1'b1, "R2", "done strobe seen", 64'(done_o), 64'd1);
        while (busy_o && guard < 20000) begin @(negedge clk); guard++; end
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ma_o == 1'b1 && busy_o == 1'b0 && done_o == 1'b0, "R1", "idle lines",
            {61'd0, ma_o, busy_o, done_o}, 64'h4);
        chk(pos_o == '0 && {err_o, warn_o, crc_fail_o, echo_err_o, timeout_o} == '0,
            "R1", "results cleared", 64'(pos_o), 64'd0);
    endtask

    task automatic good_frame(input logic [31:0] p, input int len, input logic en,
                              input logic wn, input int busy, input logic cdm,
                              input int lt, input int dv, input string req);
        run_frame(p, len, en, wn, busy, cdm, lt, dv, 0, 0, 0, 0);
        exp_pos = s_pos; exp_err = !en; exp_warn = !wn;
        chk(pos_o == exp_pos, req, "position", 64'(pos_o), 64'(exp_pos));
        chk(crc_fail_o == 1'b0 && timeout_o == 1'b0, req, "clean frame flags",
            {62'd0, crc_fail_o, timeout_o}, 64'd0);
        chk(echo_err_o == 1'b0, "R8", "echo matches", 64'(echo_err_o), 64'd0);
        chk(cdm_seen == cdm, "R7", "control bit seen by sensor", 64'(cdm_seen), 64'(cdm));
        chk(ma_o == 1'b1, "R7", "clock back high after hold", 64'(ma_o), 64'd1);
        exp_prev_cdm = cdm;
    endtask

    task automatic t_basic();
        good_frame(32'h00A5_5C3E, 24, 1, 1, 2, 1, 1, 4, "R2");
        chk(err_o == 1'b0 && warn_o == 1'b0, "R6", "no error/warning",
            {62'd0, err_o, warn_o}, 64'd0);
    endtask

    task automatic t_delays();
        good_frame(32'hDEAD_BEEF, 32, 1, 1, 0, 0, 9, 8, "R3");
        good_frame(32'h0000_005A, 8, 1, 1, 1, 1, 1, 2, "R3");
        good_frame(32'h0001_2345, 20, 1, 1, 0, 0, 3, 5, "R3");
    endtask

    task automatic t_busy();
        good_frame(32'h0000_3C3C, 16, 1, 1, 20, 1, 2, 3, "R4");
    endtask

    task automatic t_err_warn();
        good_frame(32'h0000_0F0F, 16, 0, 1, 1, 0, 1, 4, "R6");
        chk(err_o == 1'b1 && warn_o == 1'b0, "R6", "error only", {62'd0, err_o, warn_o}, 64'h2);
        good_frame(32'h0000_F0F0, 16, 1, 0, 1, 1, 1, 4, "R6");
        chk(err_o == 1'b0 && warn_o == 1'b1, "R6", "warning only", {62'd0, err_o, warn_o}, 64'h1);
    endtask

    task automatic t_lengths();
        good_frame(32'h0000_0001, 1, 1, 1, 0, 0, 1, 4, "R11");
        good_frame(32'hFFFF_FFFE, 32, 1, 1, 0, 1, 1, 4, "R11");
        good_frame(32'hFFFF_FFFF, 5, 1, 1, 0, 0, 1, 4, "R11");
        chk(pos_o == 32'h1F, "R11", "right-aligned upper zeros", 64'(pos_o), 64'h1F);
    endtask

    task automatic t_crc_bad();
        run_frame(32'h0000_1234, 16, 0, 0, 0, 1, 1, 4, 0, 1, 0, 0);
        chk(crc_fail_o == 1'b1, "R5", "code failure flagged", 64'(crc_fail_o), 64'd1);
        chk(pos_o == exp_pos, "R5", "position kept", 64'(pos_o), 64'(exp_pos));
        chk(err_o == exp_err && warn_o == exp_warn, "R5", "flags kept",
            {62'd0, err_o, warn_o}, {62'd0, exp_err, exp_warn});
        exp_prev_cdm = 1'b1;
    endtask

    task automatic t_echo();
        run_frame(32'h0000_0077, 8, 1, 1, 0, 0, 1, 4, 1, 0, 0, 0);
        chk(echo_err_o == 1'b1, "R8", "echo mismatch flagged", 64'(echo_err_o), 64'd1);
        chk(pos_o == 32'h77, "R8", "data still accepted", 64'(pos_o), 64'h77);
        exp_pos = 32'h77; exp_prev_cdm = 1'b0;
    endtask

    task automatic t_noack();
        run_frame(32'h0000_ABCD, 16, 1, 1, 0, 1, 1, 4, 0, 0, 0, 1);
        chk(timeout_o == 1'b1, "R9", "acknowledge timeout", 64'(timeout_o), 64'd1);
        chk(pos_o == exp_pos && crc_fail_o == 1'b0 && echo_err_o == 1'b0, "R9",
            "aborted frame leaves results", 64'(pos_o), 64'(exp_pos));
        chk(ma_o == 1'b1, "R9", "clock high after abort", 64'(ma_o), 64'd1);
    endtask

    task automatic t_hang();
        run_frame(32'h0000_4321, 16, 1, 1, 0, 1, 1, 2, 0, 0, 1, 0);
        chk(timeout_o == 1'b1, "R10", "start bit timeout", 64'(timeout_o), 64'd1);
        chk(pos_o == exp_pos, "R10", "position kept", 64'(pos_o), 64'(exp_pos));
        good_frame(32'h0000_0BAD, 12, 1, 1, 0, 0, 1, 4, "R10");
    endtask

    initial begin
        s_pos = '0; s_len = 24; s_busy = 0; lat = 1; s_errn = 1; s_warnn = 1;
        s_flip = 0; s_corrupt = 0; s_hang = 0; s_noack = 0; pipe = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        t_reset();
        t_basic();
        t_delays();
        t_busy();
        t_err_warn();
        t_lengths();
        t_crc_bad();
        t_echo();
        t_noack();
        t_hang();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule